// File: doc/BRIEF.md
# Programmable SPI Serial Clock Generator

This block produces the serial clock for an SPI master from the system clock. Division happens in two stages. A 13-bit prescaler first turns the system clock into a tick every P+1 cycles. A 6-bit cycle counter then advances on each tick and wraps after N+1 ticks. Two compare points inside that period, H and L, decide when the serial clock rises and falls. A bypass flag replaces the divided clock with the system clock itself.

Shift logic uses the clock level together with two strobes, each one system cycle wide. One marks a rising edge of the divided clock and the other a falling edge. All settings sit in one 32-bit word, and that word is taken only while a configure-enable input is high. While configure-enable is high the block stays idle and cleared, so the first period after configuration starts from a known point.

Top module: `sclk_gen`

## Requirements
- R1: The configuration word is laid out as follows: bits 5:0 hold the fall point L, bits 11:6 the rise point H, bits 17:12 the period count N, bits 30:18 the prescale value P, and bit 31 the bypass flag.
- R2: With bypass clear and H different from L, one full `sclk` period lasts (P+1)*(N+1) system cycles.
- R3: In the divided clock, `sclk` rises on the prescaler tick where the cycle counter equals H and falls on the tick where it equals L. With the recommended L = N and H = floor((N+1)/2) - 1, the high time is (N-H)*(P+1) cycles.
- R4: When H equals L (for example N = H = L = 0), `sclk` toggles on every matching tick. The period is then 2*(P+1) and the high time is P+1.
- R5: With bypass set, `sclk` follows `clk` starting one cycle after configure-enable falls, and `riseStb` and `fallStb` both stay at 1.
- R6: While `cfgEn` is 1, the word on `cfgWord` is loaded every cycle and one cycle later `sclk`, `riseStb` and `fallStb` are all 0. While `cfgEn` is 0, changes on `cfgWord` have no effect on the output.
- R7: A synchronous reset drives `sclk` and both strobes to 0 and clears the stored configuration to all zeros (bypass off, P = N = H = L = 0). After reset is released, `sclk` toggles every system cycle.
- R8: In the divided clock, `riseStb` is 1 for exactly the first cycle in which `sclk` is 1, and `fallStb` is 1 for exactly the first cycle in which `sclk` is 0 again.
- R9: Count the clock edges from the first edge at which `cfgEn` is sampled 0, calling that edge number 1. The first `riseStb` appears after edge number 1 + P + H*(P+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgEn | input | 1 | Configure-enable; while high the word is loaded and the outputs are held cleared |
| cfgWord | input | 32 | Configuration word {bypass, P, N, H, L} |
| sclk | output | 1 | Serial clock (divided or bypassed) |
| riseStb | output | 1 | One-cycle strobe on a rising edge of `sclk` |
| fallStb | output | 1 | One-cycle strobe on a falling edge of `sclk` |

## Verification
Each output of the divided clock comes from a register behind the counters, so it changes at a clock edge. The bench reads every output 1 ns after a rising edge. The first rise is due 1 + P + H*(P+1) edges after configure-enable is released. The fall then follows after the high time, and the next rise after one full period. The bench counts edges from the release and compares those counts with the values in its table. Outputs are cleared one edge after configure-enable or reset goes high, and the bypass path takes over one edge after release. The bench therefore waits past those edges and reads `sclk` in the middle of both the high and the low phase of `clk`.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

  // Per-cycle strobes from the counter control to the clock datapath.
  typedef struct packed {
    logic clear;    // reset or configure-enable: hold everything idle
    logic bypass;   // stored bypass flag
    logic hitHigh;  // prescaler tick with cycle counter at the rise point
    logic hitLow;   // prescaler tick with cycle counter at the fall point
  } sclkCtl_t;

endpackage

// File: rtl/sclk_gen_ctrl.sv
module sclk_gen_ctrl
  import sclk_gen_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int PRE_W = 13,
  localparam int CFG_W = 3 * CNT_W + PRE_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgEn,
  input  logic [CFG_W-1:0] cfgWord,
  output sclkCtl_t         ctl
);

  localparam int LOW_LSB  = 0;
  localparam int HIGH_LSB = CNT_W;
  localparam int LEN_LSB  = 2 * CNT_W;
  localparam int PRE_LSB  = 3 * CNT_W;
  localparam int BYP_BIT  = 3 * CNT_W + PRE_W;

  logic [CFG_W-1:0] cfgReg;
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] cycCnt;

  logic [CNT_W-1:0] cfgLow, cfgHigh, cfgLen;
  logic [PRE_W-1:0] cfgPre;
  logic             cfgByp;
  logic             preTick;
  logic             cycWrap;

  assign cfgLow  = cfgReg[LOW_LSB  +: CNT_W];
  assign cfgHigh = cfgReg[HIGH_LSB +: CNT_W];
  assign cfgLen  = cfgReg[LEN_LSB  +: CNT_W];
  assign cfgPre  = cfgReg[PRE_LSB  +: PRE_W];
  assign cfgByp  = cfgReg[BYP_BIT];

  assign preTick = (preCnt == cfgPre);
  assign cycWrap = (cycCnt == cfgLen);

  // Configuration register: loads only while configure-enable is high.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfgReg <= '0;
    end else if (cfgEn) begin
      cfgReg <= cfgWord;
    end
  end

  // Prescaler stage: counts 0..P, ticks on P.
  always_ff @(posedge clk) begin
    if (rst || cfgEn) begin
      preCnt <= '0;
    end else if (preTick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // Cycle stage: advances per tick, wraps from N to 0.
  always_ff @(posedge clk) begin
    if (rst || cfgEn) begin
      cycCnt <= '0;
    end else if (preTick) begin
      cycCnt <= cycWrap ? '0 : cycCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.clear   = rst | cfgEn;
    ctl.bypass  = cfgByp;
    ctl.hitHigh = preTick && (cycCnt == cfgHigh) && !(rst || cfgEn);
    ctl.hitLow  = preTick && (cycCnt == cfgLow)  && !(rst || cfgEn);
  end

  // R2: prescaler never passes its terminal value.
  p_pre_bound_r2: assert property (@(posedge clk) disable iff (rst)
    preCnt <= cfgPre);

  // R2: cycle counter never passes N.
  p_cyc_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cycCnt <= cfgLen);

  // R6: stored configuration is frozen while configure-enable is low.
  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    !cfgEn |=> $stable(cfgReg));

  // R6: counters restart from zero after a configure cycle.
  p_cfg_clears_r6: assert property (@(posedge clk) disable iff (rst)
    cfgEn |=> (preCnt == '0) && (cycCnt == '0));

endmodule

// File: rtl/sclk_gen_dp.sv
module sclk_gen_dp
  import sclk_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  sclkCtl_t ctl,
  output logic     sclk,
  output logic     riseStb,
  output logic     fallStb
);

  logic level;
  logic riseReg;
  logic fallReg;
  logic bypOn;
  logic nextLevel;

  // Rise and fall at the same tick (H == L) means toggle.
  always_comb begin
    nextLevel = level;
    if (ctl.hitHigh && ctl.hitLow) begin
      nextLevel = !level;
    end else if (ctl.hitHigh) begin
      nextLevel = 1'b1;
    end else if (ctl.hitLow) begin
      nextLevel = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      level   <= 1'b0;
      riseReg <= 1'b0;
      fallReg <= 1'b0;
      bypOn   <= 1'b0;
    end else begin
      level   <= nextLevel;
      riseReg <= nextLevel && !level;
      fallReg <= !nextLevel && level;
      bypOn   <= ctl.bypass;
    end
  end

  assign sclk    = bypOn ? clk : level;
  assign riseStb = bypOn | riseReg;
  assign fallStb = bypOn | fallReg;

  // R8: a rise strobe lasts a single cycle in the divided clock.
  p_rise_single_r8: assert property (@(posedge clk) disable iff (rst)
    (riseReg && !bypOn) |=> !riseReg);

  // R8: a rise strobe coincides with the first high cycle of the level.
  p_rise_level_r8: assert property (@(posedge clk) disable iff (rst)
    riseReg |-> (level && !$past(level)));

  // R8: a fall strobe coincides with the first low cycle of the level.
  p_fall_level_r8: assert property (@(posedge clk) disable iff (rst)
    fallReg |-> (!level && $past(level)));

  // R6: configure-enable leaves the outputs idle on the next cycle.
  p_clear_idle_r6: assert property (@(posedge clk) disable iff (rst)
    ctl.clear |=> (!level && !riseStb && !fallStb));

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_gen_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int PRE_W = 13
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfgEn,
  input  logic [31:0] cfgWord,
  output logic        sclk,
  output logic        riseStb,
  output logic        fallStb
);

  sclkCtl_t ctl;

  sclk_gen_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cfgEn   (cfgEn),
    .cfgWord (cfgWord),
    .ctl     (ctl)
  );

  sclk_gen_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .sclk    (sclk),
    .riseStb (riseStb),
    .fallStb (fallStb)
  );

endmodule

// File: tb/sclk_gen_bench.sv
`timescale 1ns/1ps
module sclk_gen_bench;

  localparam int HALF = 4;  // 125 MHz
  localparam int WAIT_MAX = 40000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgEn = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        sclk, riseStb, fallStb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #HALF clk = ~clk;

  sclk_gen u_sclk_gen (
    .clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgWord(cfgWord),
    .sclk(sclk), .riseStb(riseStb), .fallStb(fallStb)
  );

  typedef struct packed {
    int p; int n; int h; int per; int hi; int first;
  } vec_t;

  // P, N, H (L = N), expected period, high time, first-rise edge count
  localparam vec_t VECS [7] = '{
    '{0,    3,  1,     4,    2,    2},
    '{2,    5,  2,    18,    9,    9},
    '{1,    0,  0,     4,    2,    2},
    '{0,    2,  0,     3,    2,    1},
    '{3,    7,  3,    32,   16,   16},
    '{0,   63, 31,    64,   32,   32},
    '{8191, 1,  0, 16384, 8192, 8192}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(input bit byp, input int p,
                                         input int n, input int h, input int l);
    // R1: {bypass[31], P[30:18], N[17:12], H[11:6], L[5:0]}
    return {byp, p[12:0], n[5:0], h[5:0], l[5:0]};
  endfunction

  task automatic configure(input logic [31:0] w);
    @(negedge clk);
    cfgEn = 1'b1;
    cfgWord = w;
    @(negedge clk);
    cfgEn = 1'b0;
  endtask

  // Counts edges until the chosen strobe is seen (sampled 1 ns after the edge).
  task automatic waitStb(input bit wantRise, output int cnt);
    cnt = 0;
    for (int i = 0; i < WAIT_MAX; i++) begin
      @(posedge clk);
      #1;
      cnt++;
      if (wantRise ? riseStb : fallStb) return;
    end
    errors++;
    $display("FAIL timeout waiting for strobe: actual %0d expected <%0d", cnt, WAIT_MAX);
  endtask

  task automatic measure(input string tag, input int expFirst, input int expHi,
                         input int expPer, input int periods);
    int first, hi, lo;
    waitStb(1'b1, first);
    chk({tag, " R9 first rise"}, first, expFirst);
    chk({tag, " R8 sclk high at rise"}, sclk, 1);
    for (int k = 0; k < periods; k++) begin
      waitStb(1'b0, hi);
      chk({tag, " R3 high time"}, hi, expHi);
      chk({tag, " R8 sclk low at fall"}, sclk, 0);
      waitStb(1'b1, lo);
      chk({tag, " R2 period"}, hi + lo, expPer);
    end
  endtask

  initial begin
    #(2 * HALF * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    // R7: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R7 sclk in reset", sclk, 0);
    chk("R7 riseStb in reset", riseStb, 0);
    chk("R7 fallStb in reset", fallStb, 0);

    // R7: zero config after reset -> toggle each cycle (R4)
    @(negedge clk);
    rst = 1'b0;
    measure("R7 post-reset", 1, 1, 2, 2);

    // Table walk: R2, R3, R4, R8, R9
    foreach (VECS[i]) begin
      configure(mkWord(1'b0, VECS[i].p, VECS[i].n, VECS[i].h, VECS[i].n));
      measure($sformatf("vec%0d", i), VECS[i].first, VECS[i].hi, VECS[i].per,
              (VECS[i].p > 100) ? 1 : 2);
    end

    // R6: writes while cfgEn low are ignored
    configure(mkWord(1'b0, 0, 3, 1, 3));
    @(negedge clk);
    cfgWord = mkWord(1'b0, 5, 9, 4, 9);
    measure("R6 ignored write", 1, 2, 4, 2);

    // R6: cfgEn clears outputs and holds them
    @(negedge clk);
    cfgEn = 1'b1;
    cfgWord = mkWord(1'b0, 0, 0, 0, 0);
    c = 0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      #1;
      if (sclk || riseStb || fallStb) c++;
    end
    chk("R6 idle while configuring", c, 0);
    @(negedge clk);
    cfgEn = 1'b0;
    measure("R6 after reconfig", 1, 1, 2, 1);

    // R5: bypass follows clk, both strobes high
    configure(mkWord(1'b1, 3, 5, 2, 5));
    repeat (2) @(posedge clk);
    #1;
    chk("R5 sclk in clk high phase", sclk, 1);
    chk("R5 riseStb held", riseStb, 1);
    chk("R5 fallStb held", fallStb, 1);
    @(negedge clk);
    #1;
    chk("R5 sclk in clk low phase", sclk, 0);

    // R7: reset leaves bypass
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R7 reset ends bypass", sclk, 0);
    chk("R7 reset clears riseStb", riseStb, 0);
    @(negedge clk);
    rst = 1'b0;
    measure("R7 reset config", 1, 1, 2, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule